// File: doc/BRIEF.md
# Memory-Streaming Negacyclic Polynomial Multiplier

This block multiplies a 256-coefficient public polynomial with 13-bit coefficients by a 256-coefficient secret polynomial with small signed coefficients. The ring is modulo x^256+1 and the coefficients are modulo 2^13. The product is added onto an accumulator polynomial that already sits in memory. The block is built for the smallest possible area. It holds one 16-coefficient window of the secret operand, a 16-coefficient reservoir that feeds that window, and two 64-bit words of the public operand. The four multiply-accumulate lanes share one set of precomputed multiples of the current public coefficient.

The accumulator is never held in registers. In every compute cycle the block writes back the accumulator word it read in the previous cycle and reads the next one. The output is organised in blocks of 16 coefficients. For each block, every public coefficient is applied over four consecutive cycles. Between public coefficients the secret window slides by one position. The next secret coefficient comes from the reservoir and is negated whenever its index wrapped below zero. Computation pauses while an operand word is fetched. When `done` pulses, the result is already in memory.

Top module: `lw_polymul`

## Requirements
- R1: After reset, `done`, `rd_en` and `wr_en` are low, and they stay low until `start` is sampled high.
- R2: At `done`, accumulator coefficient k holds (its initial value + sum over i,j with i+j≡k of ±a[i]·s[j]) mod 8192. The memory layout is as follows. Secret word w at `sec_base`+w holds s[16w+t] as 4-bit two's complement in bits 4t+3:4t, with valid values −4..4. The public coefficients are packed back to back, LSB first, as 13-bit fields over 52 words from `pub_base`. Coefficient k of the accumulator is in word `acc_base`+k/4, bits 16(k%4)+12 : 16(k%4).
- R3: Bits 15:13 of each 16-bit accumulator slot are ignored on input and written as zero.
- R4: One product performs exactly 16384 accumulator writes. Write n goes to `acc_base` + 4·(n div 1024) + (n mod 4).
- R5: Every accumulator write targets the word that was read from the accumulator region in the immediately preceding cycle. An accumulator word is never read in the same cycle as a write to it.
- R6: One product reads exactly 272 secret words and 832 public words. Every read address lies inside one of the three regions.
- R7: `done` is a one-cycle pulse that occurs between 16384 and 18700 cycles after `start` is sampled.
- R8: `start` has no effect while a product is in progress. After `done` there is no further memory traffic and no second pulse.
- R9: A term whose index sum i+j reaches 256 is subtracted, including when the secret coefficient is negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a product (sampled in idle only) |
| sec_base | input | AW | First word of the secret operand |
| pub_base | input | AW | First word of the public operand |
| acc_base | input | AW | First word of the accumulator |
| rd_en | output | 1 | Memory read request |
| rd_addr | output | AW | Memory read address |
| rd_data | input | 64 | Read data, one cycle after the request |
| wr_en | output | 1 | Memory write request |
| wr_addr | output | AW | Memory write address |
| wr_data | output | 64 | Memory write data |
| done | output | 1 | Product complete |

## Verification
The bench builds the block with the default AW of 10. It places the three regions at words 0, 64 and 128, so a read or write routed to the wrong region or at the wrong offset shows up as an address outside its window. Because the full 256-coefficient size is used, each case walks all 16 output blocks, every reservoir refill including the wrapped and negated ones, and all 52 public words with coefficients that straddle word boundaries. The cases are directed single-term wrap products, saturated operands and random operands with junk in the slot padding.

// File: rtl/lw_polymul.sv
module lw_polymul #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] sec_base,
  input  logic [AW-1:0] pub_base,
  input  logic [AW-1:0] acc_base,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic [63:0]   rd_data,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [63:0]   wr_data,
  output logic          done
);
  localparam int QW     = 13;
  localparam int PWORDS = 256 * QW / 64;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_WAIT, S_FIN} st_t;
  localparam logic [1:0] K_WIN = 2'd0, K_RES = 2'd1, K_PUB = 2'd2;

  st_t         st;
  logic [1:0]  kind, q, pcnt;
  logic [3:0]  blk;
  logic [7:0]  ci;
  logic [6:0]  off;
  logic [5:0]  pw;
  logic [4:0]  rcnt, rnext;
  logic        win_ok;
  logic [63:0] win, res, resn;
  logic [127:0] pbuf;
  logic        wb_v;
  logic [AW-1:0] wb_addr;
  logic [QW-1:0] wb_a;
  logic [15:0] wb_s;

  logic need_win, need_res, need_pub, need, ld, acc_rd, fresh;
  logic [3:0] sw_idx;
  logic [6:0] noff;
  logic [QW-1:0] a_cur, m1, m2, m3, m4;

  assign need_win = !win_ok;
  assign need_res = (rcnt == 5'd0) && (rnext <= 5'd16);
  assign need_pub = (pcnt < 2'd2) && (pw < 6'(PWORDS));
  assign need     = need_win | need_res | need_pub;
  assign ld       = (st == S_RUN) && (q == 2'd0) && need;
  assign acc_rd   = (st == S_RUN) && !((q == 2'd0) && need);
  assign fresh    = ((st == S_IDLE) && start) ||
                    (acc_rd && q == 2'd3 && ci == 8'd255 && blk != 4'd15);
  assign sw_idx   = blk - rnext[3:0];
  assign noff     = off + 7'd13;
  assign a_cur    = pbuf[off +: QW];

  assign rd_en   = acc_rd | ld;
  assign rd_addr = acc_rd   ? acc_base + AW'({blk, q}) :
                   need_win ? sec_base + AW'(blk) :
                   need_res ? sec_base + AW'(sw_idx) :
                              pub_base + AW'(pw);

  for (genvar g = 0; g < 16; g++) begin : g_neg
    assign resn[4*g +: 4] = -rd_data[4*g +: 4];
  end

  assign m1 = wb_a;
  assign m2 = wb_a << 1;
  assign m3 = wb_a + (wb_a << 1);
  assign m4 = wb_a << 2;

  for (genvar l = 0; l < 4; l++) begin : g_lane
    logic [3:0] sv;
    logic [2:0] mag;
    logic [QW-1:0] pr, term;
    assign sv   = wb_s[4*l +: 4];
    assign mag  = sv[3] ? 3'(-sv) : sv[2:0];
    assign pr   = (mag == 3'd1) ? m1 : (mag == 3'd2) ? m2 :
                  (mag == 3'd3) ? m3 : (mag == 3'd4) ? m4 : '0;
    assign term = sv[3] ? -pr : pr;
    assign wr_data[16*l +: 16] = {3'b000, rd_data[16*l +: QW] + term};
  end

  assign wr_en   = wb_v;
  assign wr_addr = wb_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; kind <= K_WIN; blk <= '0; ci <= '0; q <= '0;
      off <= '0; pcnt <= '0; pw <= '0; rcnt <= '0; rnext <= 5'd1;
      win_ok <= 1'b0; win <= '0; res <= '0; pbuf <= '0;
      wb_v <= 1'b0; wb_addr <= '0; wb_a <= '0; wb_s <= '0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      wb_v <= acc_rd;
      if (acc_rd) begin
        wb_addr <= rd_addr;
        wb_a    <= a_cur;
        wb_s    <= win[16*q +: 16];
      end
      case (st)
        S_IDLE: if (start) st <= S_RUN;
        S_RUN: begin
          if (ld) begin
            kind <= need_win ? K_WIN : (need_res ? K_RES : K_PUB);
            st   <= S_WAIT;
          end else begin
            q <= q + 2'd1;
            if (q == 2'd3) begin
              if (ci == 8'd255) begin
                ci <= '0;
                if (blk == 4'd15) st <= S_FIN;
                else blk <= blk + 4'd1;
              end else begin
                ci   <= ci + 8'd1;
                win  <= {win[59:0], res[63:60]};
                res  <= {res[59:0], 4'b0000};
                rcnt <= rcnt - 5'd1;
                if (noff[6]) begin
                  pbuf <= {64'b0, pbuf[127:64]};
                  off  <= noff - 7'd64;
                  pcnt <= pcnt - 2'd1;
                end else begin
                  off <= noff;
                end
              end
            end
          end
        end
        S_WAIT: begin
          st <= S_RUN;
          case (kind)
            K_WIN: begin win <= rd_data; win_ok <= 1'b1; end
            K_RES: begin
              res   <= (rnext > {1'b0, blk}) ? resn : rd_data;
              rcnt  <= 5'd16;
              rnext <= rnext + 5'd1;
            end
            default: begin
              if (pcnt == 2'd0) pbuf[63:0] <= rd_data;
              else              pbuf[127:64] <= rd_data;
              pcnt <= pcnt + 2'd1;
              pw   <= pw + 6'd1;
            end
          endcase
        end
        default: begin done <= 1'b1; st <= S_IDLE; end
      endcase
      if (fresh) begin
        if (st == S_IDLE) blk <= '0;
        ci <= '0; q <= '0; off <= '0; pcnt <= '0; pw <= '0;
        rcnt <= '0; rnext <= 5'd1; win_ok <= 1'b0;
      end
    end
  end

  // R5
  wb_follows_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(rd_en) && wr_addr == $past(rd_addr));

  // R5
  no_rmw_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && wr_en) |-> rd_addr != wr_addr);

  // R4
  wr_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr - acc_base) % 4 != 0) |-> $past(wr_en) && wr_addr == $past(wr_addr) + AW'(1));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  pub_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && q == 2'd0) |-> ({1'b0, off} + 8'd13) <= {pcnt, 6'b0});

  // R9
  res_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && q == 2'd3 && ci != 8'd255) |-> rcnt != 5'd0);
endmodule

// File: tb/lw_polymul_tb_top.sv
`timescale 1ns/1ps
module lw_polymul_tb_top;
  localparam int AW = 10;
  localparam int SEC_B = 0, PUB_B = 64, ACC_B = 128;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic rd_en, wr_en, done;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [63:0] rd_data, wr_data;
  logic pl_we = 1'b0;
  logic [AW-1:0] pl_a = '0;
  logic [63:0] pl_d = '0;
  logic [63:0] mem [0:1023];

  int n_cmp = 0, n_bad = 0, tick = 0;
  int n_wr, n_sec, n_pub, n_accrd;
  bit mon_on = 1'b0, pv_acc = 1'b0;
  logic [AW-1:0] pv_addr;

  always #10 clk = ~clk;

  lw_polymul #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .sec_base(AW'(SEC_B)), .pub_base(AW'(PUB_B)), .acc_base(AW'(ACC_B)),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .done(done));

  always_ff @(posedge clk) begin
    if (pl_we) mem[pl_a] <= pl_d;
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    tick++;
    if (tick > 195000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected below 195000", tick);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // cycle-by-cycle traffic model: order of writes, pairing with reads, regions
  always @(negedge clk) begin
    if (mon_on) begin
      if (wr_en) begin
        chk(pv_acc && wr_addr == pv_addr, "R5", "write pairs prior read",
            64'(wr_addr), pv_acc ? 64'(pv_addr) : 64'hffff);
        chk(int'(wr_addr) == ACC_B + 4 * (n_wr / 1024) + n_wr % 4, "R4", "write order",
            64'(wr_addr), 64'(ACC_B + 4 * (n_wr / 1024) + n_wr % 4));
        n_wr++;
      end
      pv_acc = 1'b0;
      if (rd_en) begin
        if (rd_addr >= AW'(ACC_B) && rd_addr < AW'(ACC_B + 64)) begin
          n_accrd++;
          pv_acc = 1'b1;
          pv_addr = rd_addr;
          if (wr_en) chk(rd_addr != wr_addr, "R5", "read hits pending write",
                         64'(rd_addr), 64'(wr_addr));
        end else if (rd_addr >= AW'(SEC_B) && rd_addr < AW'(SEC_B + 16)) n_sec++;
        else if (rd_addr >= AW'(PUB_B) && rd_addr < AW'(PUB_B + 52)) n_pub++;
        else chk(1'b0, "R6", "read outside regions", 64'(rd_addr), 64'(0));
      end
    end
  end

  task automatic put(input int adr, input logic [63:0] d);
    pl_we = 1'b1; pl_a = AW'(adr); pl_d = d;
    @(negedge clk);
    pl_we = 1'b0;
  endtask

  task automatic run_case(input int mode);
    int a[256], s[256], ini[256], e[256];
    logic [3327:0] pv;
    logic [63:0] w, x;
    int cyc, dn, act;
    bit seen;
    string rq;
    for (int i = 0; i < 256; i++) begin
      case (mode)
        0: begin a[i] = (i == 255) ? 5 : 0; s[i] = (i == 1) ? 3 : 0; ini[i] = 0; end
        2: begin a[i] = 8191; s[i] = (i % 2) ? -4 : 4; ini[i] = 8191; end
        4: begin a[i] = (i == 200) ? 1 : 0; s[i] = (i == 100) ? -4 : 0; ini[i] = (i == 44) ? 10 : 0; end
        default: begin
          a[i] = int'($urandom % 8192); s[i] = int'($urandom % 9) - 4; ini[i] = int'($urandom % 8192);
        end
      endcase
      e[i] = ini[i];
    end
    for (int i = 0; i < 256; i++)
      for (int j = 0; j < 256; j++)
        if (i + j >= 256) e[(i + j) % 256] -= a[i] * s[j];
        else              e[i + j] += a[i] * s[j];
    for (int k = 0; k < 256; k++) e[k] = ((e[k] % 8192) + 8192) % 8192;

    @(negedge clk);
    for (int k = 0; k < 16; k++) begin
      for (int t = 0; t < 16; t++) w[4*t +: 4] = 4'(s[16*k + t]);
      put(SEC_B + k, w);
    end
    for (int i = 0; i < 256; i++) pv[13*i +: 13] = 13'(ini[i] * 0 + a[i]);
    for (int k = 0; k < 52; k++) put(PUB_B + k, pv[64*k +: 64]);
    for (int k = 0; k < 64; k++) begin
      for (int l = 0; l < 4; l++) w[16*l +: 16] = {3'($urandom), 13'(ini[4*k + l])};
      put(ACC_B + k, w);
    end

    n_wr = 0; n_sec = 0; n_pub = 0; n_accrd = 0; mon_on = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1; seen = 1'b0;
    while (!seen && cyc < 25000) begin
      @(negedge clk);
      cyc++;
      start = (mode == 3 && (cyc == 3000 || cyc == 9000));
      if (done) seen = 1'b1;
    end
    start = 1'b0;
    chk(seen && cyc >= 16384 && cyc <= 18700, "R7", "done latency", 64'(cyc), 64'(18700));
    chk(n_wr == 16384, "R4", "accumulator write count", 64'(n_wr), 64'(16384));
    chk(n_accrd == 16384, "R5", "accumulator read count", 64'(n_accrd), 64'(16384));
    chk(n_sec == 272, "R6", "secret read count", 64'(n_sec), 64'(272));
    chk(n_pub == 832, "R6", "public read count", 64'(n_pub), 64'(832));
    rq = (mode == 0 || mode == 4) ? "R9" : "R2/R3";
    for (int k = 0; k < 64; k++) begin
      for (int l = 0; l < 4; l++) x[16*l +: 16] = {3'b000, 13'(e[4*k + l])};
      chk(mem[ACC_B + k] === x, rq, $sformatf("acc word %0d", k), mem[ACC_B + k], x);
    end
    dn = 0; act = 0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (done) dn++;
      if (rd_en || wr_en) act++;
    end
    chk(dn == 0, "R7", "done longer than one cycle or repeated", 64'(dn), 64'(0));
    chk(act == 0, "R8", "traffic after done", 64'(act), 64'(0));
    mon_on = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      chk(!done && !rd_en && !wr_en, "R1", "quiet after reset",
          {61'b0, done, rd_en, wr_en}, 64'(0));
    end
    run_case(0);
    run_case(4);
    run_case(2);
    run_case(1);
    run_case(3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule